// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block turns a virtual address into a physical address by searching a small set of cached translations. Every stored entry is compared against the virtual page number of the request in the same cycle, so any translation may live in any slot. When one entry matches, the block checks the requested access type against that entry's read and write rights. If the access is allowed, the physical page number is joined to the untouched page offset to form the result. If the access is not allowed, the block reports a protection fault. When nothing matches, it reports a miss so that an external page-table walker can fetch the translation.

The walker returns translations through a refill port. A refill goes into a free slot when one exists. Otherwise it displaces the least recently used entry. A flush input empties the whole array in a single cycle. Lookups are accepted every cycle and answered one cycle later, through registered outputs.

Top module: `tlb_xlate`

## Requirements
- R1: Any virtual page number can be refilled into any entry. A lookup compares its page number against every valid entry in the cycle it is presented.
- R2: Each cycle with `req_valid` high produces exactly one response, with `rsp_valid` high in the next cycle. A new request may be presented in every cycle. `rsp_valid` is low in the cycle after a cycle with no request.
- R3: A hit occurs when a valid entry matches and the entry permits the access. On a hit, `rsp_hit`=1 and `rsp_paddr` = {entry physical page number, `req_vaddr[OFF_W-1:0]`}, where OFF_W = log2(PAGE_BYTES) (12 by default).
- R4: A write (`req_write`=1) needs the entry's write right, and a read (`req_write`=0) needs its read right. A matching access without the needed right gives `rsp_fault`=1, `rsp_hit`=0 and `rsp_paddr`=0.
- R5: When no valid entry matches, the response has `rsp_miss`=1 and `rsp_paddr`=0.
- R6: While `rsp_valid` is high, exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` is high. While `rsp_valid` is low, all response outputs are zero.
- R7: When at least one entry is invalid, a refill writes the invalid entry with the lowest index.
- R8: When every entry is valid, a refill replaces the least recently used entry, judged by recency at the start of that cycle. A matching lookup (hit or fault) and a refill each make their entry the most recent. When both happen in the same cycle, the lookup's entry is marked first and the refill's entry second.
- R9: A refill whose virtual page number already matches a valid entry overwrites that entry, so no two valid entries share a page number.
- R10: `flush_all` invalidates every entry in one cycle. It overrides a refill presented in the same cycle, and that refill is dropped.
- R11: A lookup that shares a cycle with a refill or a flush is answered from the contents the array held before that cycle.
- R12: While `rst` is high and after it falls, all entries are invalid and all response outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Response present (one cycle after the request) |
| rsp_hit | output | 1 | Translation found and access permitted |
| rsp_miss | output | 1 | No translation; page-table walk needed |
| rsp_fault | output | 1 | Translation found but access not permitted |
| rsp_paddr | output | PA_W | Physical address on a hit, zero otherwise |
| fill_valid | input | 1 | Refill an entry this cycle |
| fill_vpn | input | VA_W-OFF_W | Virtual page number of the refill |
| fill_ppn | input | PA_W-OFF_W | Physical page number of the refill |
| fill_read_ok | input | 1 | Read right of the refilled entry |
| fill_write_ok | input | 1 | Write right of the refilled entry |
| flush_all | input | 1 | Invalidate every entry |

## Verification
A corrupted valid bit or tag shows up at the ports on the very next lookup of that page. The response appears one cycle after the request, as a miss where a hit belongs, or as a stale physical page. A wrong rights bit turns a hit into a fault, or a fault into a hit, in that same response cycle. Recency errors stay hidden until the array is full. They then surface at a later lookup of the page that the wrong victim held, often many cycles after the faulty update. For that reason the bench keeps its own independent recency model and runs a long mixed stream over a page set larger than the array.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // Access rights held by one translation entry
    typedef struct packed {
        logic rd;
        logic wr;
    } perm_t;

    // Outcome of one lookup
    typedef enum logic [1:0] {
        RES_NONE  = 2'd0,
        RES_HIT   = 2'd1,
        RES_MISS  = 2'd2,
        RES_FAULT = 2'd3
    } tlb_res_e;

    // True when the rights allow the requested access kind
    function automatic logic access_ok(input perm_t p, input logic is_write);
        return is_write ? p.wr : p.rd;
    endfunction

endpackage

// File: rtl/tlb_lru.sv
module tlb_lru #(
    parameter int ENTRIES = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       touch_a_en,
    input  logic [$clog2(ENTRIES)-1:0] touch_a_idx,
    input  logic                       touch_b_en,
    input  logic [$clog2(ENTRIES)-1:0] touch_b_idx,
    output logic [$clog2(ENTRIES)-1:0] lru_idx
);
    localparam int IW = $clog2(ENTRIES);
    localparam logic [IW-1:0] OLDEST = IW'(ENTRIES - 1);

    // Each entry carries a distinct age; 0 is most recent, ENTRIES-1 oldest
    logic [IW-1:0] age_q [ENTRIES];
    logic [IW-1:0] age_a [ENTRIES];
    logic [IW-1:0] age_n [ENTRIES];
    logic [IW-1:0] ref_a, ref_b;
    logic [ENTRIES-1:0] oldest_vec;

    // Two ordered touches: lookup first, refill second
    always_comb begin
        ref_a = age_q[touch_a_idx];
        for (int i = 0; i < ENTRIES; i++) begin
            age_a[i] = age_q[i];
            if (touch_a_en) begin
                if (IW'(i) == touch_a_idx)
                    age_a[i] = '0;
                else if (age_q[i] < ref_a)
                    age_a[i] = IW'(age_q[i] + 1'b1);
            end
        end
        ref_b = age_a[touch_b_idx];
        for (int i = 0; i < ENTRIES; i++) begin
            age_n[i] = age_a[i];
            if (touch_b_en) begin
                if (IW'(i) == touch_b_idx)
                    age_n[i] = '0;
                else if (age_a[i] < ref_b)
                    age_n[i] = IW'(age_a[i] + 1'b1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++)
                age_q[i] <= IW'(i);
        end else begin
            for (int i = 0; i < ENTRIES; i++)
                age_q[i] <= age_n[i];
        end
    end

    always_comb begin
        lru_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            oldest_vec[i] = (age_q[i] == OLDEST);
            if (oldest_vec[i])
                lru_idx = lru_idx | IW'(i);
        end
    end

    // R8: ages stay a permutation, so exactly one entry is the oldest
    p_one_victim_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot(oldest_vec));

    // R8: a refill touch makes that entry the most recent
    p_fill_most_recent_r8: assert property (@(posedge clk) disable iff (rst)
        touch_b_en |=> (age_q[$past(touch_b_idx)] == '0));

endmodule

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 22
) (
    input  logic                       clk,
    input  logic                       rst,
    // lookup search
    input  logic [VPN_W-1:0]           lk_vpn,
    output logic                       lk_hit,
    output logic [$clog2(ENTRIES)-1:0] lk_idx,
    output logic [PPN_W-1:0]           lk_ppn,
    output perm_t                      lk_perm,
    // refill search (duplicate detection and free slot)
    input  logic [VPN_W-1:0]           fl_vpn,
    output logic                       fl_hit,
    output logic [$clog2(ENTRIES)-1:0] fl_idx,
    output logic                       free_any,
    output logic [$clog2(ENTRIES)-1:0] free_idx,
    // write port
    input  logic                       wr_en,
    input  logic [$clog2(ENTRIES)-1:0] wr_idx,
    input  logic [VPN_W-1:0]           wr_vpn,
    input  logic [PPN_W-1:0]           wr_ppn,
    input  perm_t                      wr_perm,
    input  logic                       flush_all
);
    localparam int IW = $clog2(ENTRIES);

    logic [ENTRIES-1:0] vld;
    logic [VPN_W-1:0]   ent_vpn  [ENTRIES];
    logic [PPN_W-1:0]   ent_ppn  [ENTRIES];
    perm_t              ent_perm [ENTRIES];
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] fl_match;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic sel;
        assign sel = wr_en && (wr_idx == IW'(e));

        always_ff @(posedge clk) begin
            if (rst || flush_all)
                vld[e] <= 1'b0;
            else if (sel)
                vld[e] <= 1'b1;
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                ent_vpn[e]  <= wr_vpn;
                ent_ppn[e]  <= wr_ppn;
                ent_perm[e] <= wr_perm;
            end
        end

        assign lk_match[e] = vld[e] && (ent_vpn[e] == lk_vpn);
        assign fl_match[e] = vld[e] && (ent_vpn[e] == fl_vpn);
    end

    // Matches are one-hot, so the selected fields can be OR-reduced
    always_comb begin
        lk_idx  = '0;
        lk_ppn  = '0;
        lk_perm = '0;
        fl_idx  = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (lk_match[e]) begin
                lk_idx     = lk_idx | IW'(e);
                lk_ppn     = lk_ppn | ent_ppn[e];
                lk_perm.rd = lk_perm.rd | ent_perm[e].rd;
                lk_perm.wr = lk_perm.wr | ent_perm[e].wr;
            end
            if (fl_match[e])
                fl_idx = fl_idx | IW'(e);
        end
    end

    assign lk_hit   = |lk_match;
    assign fl_hit   = |fl_match;
    assign free_any = ~&vld;

    // Lowest-index free entry
    always_comb begin
        free_idx = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (!vld[e])
                free_idx = IW'(e);
        end
    end

    // R9: refills never create a second entry for the same page
    p_single_match_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match) && $onehot0(fl_match));

    // R10: a flush leaves no valid entry behind
    p_flush_empties_r10: assert property (@(posedge clk) disable iff (rst)
        flush_all |=> (vld == '0));

    // R7: a refill into a non-full array fills a slot that was free
    p_fill_free_slot_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !flush_all && !fl_hit && free_any) |-> !vld[wr_idx]);

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int ENTRIES    = 32,
    parameter int VA_W       = 32,
    parameter int PA_W       = 34,
    parameter int PAGE_BYTES = 4096
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    input  logic [VA_W-1:0]               req_vaddr,
    input  logic                          req_write,
    output logic                          rsp_valid,
    output logic                          rsp_hit,
    output logic                          rsp_miss,
    output logic                          rsp_fault,
    output logic [PA_W-1:0]               rsp_paddr,
    input  logic                          fill_valid,
    input  logic [VA_W-$clog2(PAGE_BYTES)-1:0] fill_vpn,
    input  logic [PA_W-$clog2(PAGE_BYTES)-1:0] fill_ppn,
    input  logic                          fill_read_ok,
    input  logic                          fill_write_ok,
    input  logic                          flush_all
);
    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;
    localparam int IW    = $clog2(ENTRIES);

    typedef struct packed {
        logic            valid;
        tlb_res_e        res;
        logic [PA_W-1:0] paddr;
    } rsp_t;

    logic [VPN_W-1:0] req_vpn;
    logic [OFF_W-1:0] req_off;
    logic             lk_hit, fl_hit, free_any;
    logic [IW-1:0]    lk_idx, fl_idx, free_idx, lru_idx, wr_idx;
    logic [PPN_W-1:0] lk_ppn;
    perm_t            lk_perm, wr_perm;
    logic             wr_en;
    rsp_t             rsp_d, rsp_q;

    assign req_vpn = req_vaddr[VA_W-1:OFF_W];
    assign req_off = req_vaddr[OFF_W-1:0];
    assign wr_perm = '{rd: fill_read_ok, wr: fill_write_ok};
    assign wr_en   = fill_valid && !flush_all;

    // Refill target: existing entry, else lowest free, else least recent
    always_comb begin
        if (fl_hit)
            wr_idx = fl_idx;
        else if (free_any)
            wr_idx = free_idx;
        else
            wr_idx = lru_idx;
    end

    tlb_cam #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PPN_W   (PPN_W)
    ) u_cam (
        .clk       (clk),
        .rst       (rst),
        .lk_vpn    (req_vpn),
        .lk_hit    (lk_hit),
        .lk_idx    (lk_idx),
        .lk_ppn    (lk_ppn),
        .lk_perm   (lk_perm),
        .fl_vpn    (fill_vpn),
        .fl_hit    (fl_hit),
        .fl_idx    (fl_idx),
        .free_any  (free_any),
        .free_idx  (free_idx),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_vpn    (fill_vpn),
        .wr_ppn    (fill_ppn),
        .wr_perm   (wr_perm),
        .flush_all (flush_all)
    );

    tlb_lru #(
        .ENTRIES (ENTRIES)
    ) u_lru (
        .clk         (clk),
        .rst         (rst),
        .touch_a_en  (req_valid && lk_hit),
        .touch_a_idx (lk_idx),
        .touch_b_en  (wr_en),
        .touch_b_idx (wr_idx),
        .lru_idx     (lru_idx)
    );

    // Classify the lookup and form the physical address
    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            if (!lk_hit) begin
                rsp_d.res = RES_MISS;
            end else if (access_ok(lk_perm, req_write)) begin
                rsp_d.res   = RES_HIT;
                rsp_d.paddr = {lk_ppn, req_off};
            end else begin
                rsp_d.res = RES_FAULT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rsp_q <= '0;
        else
            rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = (rsp_q.res == RES_HIT);
    assign rsp_miss  = (rsp_q.res == RES_MISS);
    assign rsp_fault = (rsp_q.res == RES_FAULT);
    assign rsp_paddr = rsp_q.paddr;

    // R2: every request is answered in the next cycle, and only then
    p_next_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R6: one outcome per response, silence otherwise
    p_one_outcome_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1));
    p_quiet_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_hit && !rsp_miss && !rsp_fault && rsp_paddr == '0));

    // R3: the page offset passes through untranslated
    p_offset_kept_r3: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (!rsp_hit || rsp_paddr[OFF_W-1:0] == $past(req_off)));

    // R4 / R5: no address leaks on a fault or a miss
    p_fault_no_addr_r4: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_paddr == '0));
    p_miss_no_addr_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> (rsp_paddr == '0));

endmodule

// File: tb/tlb_xlate_test.sv
`timescale 1ns/1ps
module tlb_xlate_test;
    localparam int N     = 32;
    localparam int VA_W  = 32;
    localparam int PA_W  = 34;
    localparam int OFF_W = 12;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [VA_W-1:0] req_vaddr = '0;
    logic req_write = 1'b0;
    logic rsp_valid, rsp_hit, rsp_miss, rsp_fault;
    logic [PA_W-1:0] rsp_paddr;
    logic fill_valid = 1'b0;
    logic [VPN_W-1:0] fill_vpn = '0;
    logic [PPN_W-1:0] fill_ppn = '0;
    logic fill_read_ok = 1'b0;
    logic fill_write_ok = 1'b0;
    logic flush_all = 1'b0;

    always #2 clk = ~clk;

    tlb_xlate uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_read_ok(fill_read_ok), .fill_write_ok(fill_write_ok),
        .flush_all(flush_all)
    );

    typedef struct {
        bit              v;
        bit              hit;
        bit              miss;
        bit              fault;
        logic [PA_W-1:0] pa;
        string           tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails  = 0;
    int tick   = 0;
    bit done   = 0;

    // Reference model of the array contents and recency
    bit               m_vld [N];
    logic [VPN_W-1:0] m_vpn [N];
    logic [PPN_W-1:0] m_ppn [N];
    bit               m_rd  [N];
    bit               m_wr  [N];
    int               m_use [N];

    function automatic int find_vpn(input logic [VPN_W-1:0] v);
        for (int i = 0; i < N; i++)
            if (m_vld[i] && m_vpn[i] == v) return i;
        return -1;
    endfunction

    function automatic int pick_slot(input logic [VPN_W-1:0] v);
        int k = find_vpn(v);
        if (k >= 0) return k;
        for (int i = 0; i < N; i++)
            if (!m_vld[i]) return i;
        k = 0;
        for (int i = 1; i < N; i++)
            if (m_use[i] < m_use[k]) k = i;
        return k;
    endfunction

    task automatic step(input bit rv, input logic [VA_W-1:0] va, input bit w,
                        input bit fv, input logic [VPN_W-1:0] fvpn,
                        input logic [PPN_W-1:0] fppn, input bit frd, input bit fwr,
                        input bit inv, input string tag);
        exp_t e;
        int   li;
        int   fi;
        @(negedge clk);
        req_valid = rv; req_vaddr = va; req_write = w;
        fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn;
        fill_read_ok = frd; fill_write_ok = fwr; flush_all = inv;
        e = '{v: rv, hit: 0, miss: 0, fault: 0, pa: '0, tag: tag};
        li = -1;
        if (rv) begin
            li = find_vpn(va[VA_W-1:OFF_W]);
            if (li < 0) e.miss = 1;
            else if (w ? m_wr[li] : m_rd[li]) begin
                e.hit = 1;
                e.pa  = {m_ppn[li], va[OFF_W-1:0]};
            end else e.fault = 1;
        end
        q.push_back(e);
        fi = pick_slot(fvpn);
        if (li >= 0) m_use[li] = 2 * tick;
        if (inv) begin
            for (int i = 0; i < N; i++) m_vld[i] = 0;
        end else if (fv) begin
            m_vld[fi] = 1; m_vpn[fi] = fvpn; m_ppn[fi] = fppn;
            m_rd[fi] = frd; m_wr[fi] = fwr; m_use[fi] = 2 * tick + 1;
        end
        tick++;
    endtask

    task automatic look(input logic [VA_W-1:0] va, input bit w, input string tag);
        step(1, va, w, 0, '0, '0, 0, 0, 0, tag);
    endtask

    task automatic fill(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p,
                        input bit rd, input bit wr, input string tag);
        step(0, '0, 0, 1, v, p, rd, wr, 0, tag);
    endtask

    task automatic idle();
        step(0, '0, 0, 0, '0, '0, 0, 0, 0, "R2");
    endtask

    // Monitor: compare each registered response against the queue
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (rsp_valid !== e.v || rsp_hit !== e.hit || rsp_miss !== e.miss ||
                rsp_fault !== e.fault || rsp_paddr !== e.pa) begin
                fails++;
                $display("FAIL %s: got v=%0b h=%0b m=%0b f=%0b pa=%h, expected v=%0b h=%0b m=%0b f=%0b pa=%h",
                         e.tag, rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_paddr,
                         e.v, e.hit, e.miss, e.fault, e.pa);
            end
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 0; m_vpn[i] = '0; m_ppn[i] = '0;
            m_rd[i] = 0; m_wr[i] = 0; m_use[i] = 0;
        end
        repeat (4) @(posedge clk);
        #1;
        // R12: reset state
        checks++;
        if (rsp_valid !== 0 || rsp_hit !== 0 || rsp_miss !== 0 || rsp_fault !== 0 || rsp_paddr !== '0) begin
            fails++;
            $display("FAIL R12: got v=%0b h=%0b m=%0b f=%0b pa=%h, expected all zero",
                     rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_paddr);
        end
        @(negedge clk); rst = 1'b0;

        // R5 / R12: empty array misses
        look(32'h1234_5ABC, 0, "R5");
        // R7: refills into free slots
        fill(20'h12345, 22'h3ABCD, 1, 1, "R7");
        fill(20'h00010, 22'h00111, 1, 0, "R7");
        fill(20'hFFFFF, 22'h3FFFF, 0, 1, "R7");
        fill(20'h00000, 22'h00222, 1, 1, "R7");
        // R3: hits with offset pass-through, back-to-back (R2)
        look(32'h1234_5ABC, 0, "R3");
        look(32'h1234_5001, 1, "R3");
        look(32'hFFFF_F7FF, 1, "R3");
        look(32'h0000_0FFF, 0, "R3");
        look(32'h0001_0000, 0, "R3");
        // R4: rights violations
        look(32'h0001_0123, 1, "R4");
        look(32'hFFFF_F456, 0, "R4");
        // R10: flush empties all
        step(0, '0, 0, 0, '0, '0, 0, 0, 1, "R10");
        look(32'h1234_5ABC, 0, "R10");
        look(32'h0000_0000, 1, "R10");

        // R1: fill every slot, look each up
        for (int i = 0; i < N; i++)
            fill(VPN_W'(20'h00100 + i), PPN_W'(22'h10000 + 7 * i), 1, (i % 2) == 1, "R1");
        for (int i = 0; i < N; i++)
            look({VPN_W'(20'h00100 + i), 12'(i * 37)}, 0, "R1");
        // R8: touch the oldest, then refill: next oldest leaves
        look({20'h00100, 12'h010}, 0, "R8");
        fill(20'h00200, 22'h2AAAA, 1, 1, "R8");
        look({20'h00101, 12'h000}, 0, "R8");
        look({20'h00100, 12'h000}, 0, "R8");
        // R8: a fault also refreshes recency
        look({20'h00102, 12'h000}, 1, "R8");
        fill(20'h00201, 22'h2BBBB, 1, 1, "R8");
        look({20'h00103, 12'h000}, 0, "R8");
        look({20'h00102, 12'h000}, 0, "R8");
        // R9: duplicate refill overwrites in place
        fill(20'h00100, 22'h15555, 0, 1, "R9");
        look({20'h00100, 12'h321}, 0, "R9");
        look({20'h00100, 12'h321}, 1, "R9");
        look({20'h00104, 12'h000}, 0, "R9");
        // R11: lookup sees pre-refill contents
        step(1, {20'h00104, 12'hABC}, 0, 1, 20'h00104, 22'h0F0F0, 1, 1, 0, "R11");
        look({20'h00104, 12'hABC}, 0, "R11");
        // R11 / R10: flush with lookup and refill in the same cycle
        step(1, {20'h00105, 12'h001}, 1, 1, 20'h00300, 22'h00333, 1, 1, 1, "R11");
        look({20'h00300, 12'h000}, 0, "R10");
        look({20'h00105, 12'h000}, 0, "R10");

        // R8: long mixed stream over more pages than entries
        for (int n = 0; n < 3000; n++) begin
            logic [VPN_W-1:0] pv;
            logic [VPN_W-1:0] lv;
            pv = VPN_W'(20'h00400 + ($urandom % 48));
            lv = VPN_W'(20'h00400 + ($urandom % 48));
            step(($urandom % 4) != 0, {lv, 12'($urandom)}, $urandom % 2,
                 ($urandom % 3) == 0, pv, 22'($urandom), $urandom % 2, $urandom % 2,
                 ($urandom % 400) == 0, "R8");
        end
        idle();
        idle();
        @(posedge clk); #2;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R2: %0d responses outstanding, expected 0", q.size());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R2: watchdog expired, got hang, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule